// File: doc/BRIEF.md
# Activation Term Serializer

This block accepts one unsigned 16-bit activation and turns it into a sequence of power-of-two terms, one term per clock. Each term carries a bit position and a sign. A downstream lane can then form activation × weight by shifting the weight left by the position and adding or subtracting the result. Because zero bits produce no term, the time spent on one activation follows the number of its nonzero digits and not its width.

The block has two modes, chosen for each activation as it is loaded. Plain mode emits one positive term for each set bit. Signed-digit mode first recodes the value into non-adjacent form. That form replaces each run of ones with a positive term one place above the run and a negative term at its bottom, which usually shortens the sequence. Positions can then reach 16, so the position field is 5 bits wide. An all-zero activation still takes one cycle: that cycle is flagged as a zero contribution and as the last term, so lanes that run in parallel stay aligned.

Loading uses a ready/valid handshake. Terms leave on a valid flag with a last marker and cannot be stalled.

Top module: `term_serializer`

## Requirements
- R1: While reset is asserted and right after it, `in_ready` is 1 and `out_valid` is 0.
- R2: An activation is captured on a rising edge where `in_valid` and `in_ready` are both 1. Its first term appears with `out_valid`=1 in the next cycle.
- R3: `in_ready` is 0 in every cycle in which `out_valid` is 1. `in_valid` and `in_act` are ignored in those cycles, so the terms being emitted do not change.
- R4: With `in_signed`=0, each set bit of the activation gives exactly one term, with `out_pos` equal to the bit index (0..15) and `out_neg`=0. An activation with k set bits takes k consecutive cycles.
- R5: The terms of one activation appear on consecutive cycles, in strictly ascending `out_pos` order.
- R6: With `in_signed`=1, the terms are the non-adjacent-form digits of the activation. No two terms of one activation have adjacent positions. `out_pos` may be 16, and `out_neg`=1 marks a digit of -1. The sum of ±2^`out_pos` over the terms equals the activation, and 0x002F gives exactly three terms: -2^0, -2^4, +2^6.
- R7: An activation of 0 in either mode gives exactly one cycle with `out_valid`=1, `out_zero`=1, `out_last`=1, `out_pos`=0 and `out_neg`=0. For any nonzero activation, `out_zero` stays 0.
- R8: `out_last` is 1 on the final term only. In the cycle after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Activation offered |
| in_ready | output | 1 | Serializer idle and able to take an activation |
| in_act | input | 16 | Activation value, unsigned |
| in_signed | input | 1 | 1 selects signed-digit recoding, 0 selects plain mode |
| out_valid | output | 1 | A term is present this cycle |
| out_pos | output | 5 | Bit position of the term (0..16) |
| out_neg | output | 1 | Term is subtracted |
| out_zero | output | 1 | Activation was zero and contributes nothing |
| out_last | output | 1 | Final term of the current activation |

## Verification
A corrupted remaining-digit mask appears as a wrong position, a wrong sign or a wrong term count in the very next term cycles. It is caught because the signed powers of two are summed at the ports and compared against the loaded value once `out_last` arrives. A busy flag that is stuck or drops early shows as `in_ready` and `out_valid` disagreeing, or as a stream cut short, within one cycle of the fault. Flawed recoding shows as adjacent signed positions or as more terms than the expected digit sequence, by the end of that activation.

// File: rtl/term_pkg.sv
package term_pkg;
    parameter int unsigned TP_ACT_W = 16;

    typedef enum logic {
        ENC_PLAIN  = 1'b0,
        ENC_SIGNED = 1'b1
    } enc_mode_e;
endpackage

// File: rtl/digit_recoder.sv
module digit_recoder #(
    parameter int unsigned ACT_W     = 16,
    parameter bit          SIGNED_EN = 1'b1,
    localparam int unsigned DW       = ACT_W + 1
) (
    input  logic [ACT_W-1:0] act,
    input  logic             signed_mode,
    output logic [DW-1:0]    pos_mask,
    output logic [DW-1:0]    neg_mask
);
    logic [DW-1:0] plain_w;
    assign plain_w = {1'b0, act};

    generate
        if (SIGNED_EN) begin : g_naf
            logic [DW-1:0] half_w, tri_w, diff_w;
            always_comb begin
                half_w = plain_w >> 1;
                tri_w  = plain_w + half_w;
                diff_w = half_w ^ tri_w;
                if (signed_mode) begin
                    pos_mask = tri_w & diff_w;
                    neg_mask = half_w & diff_w;
                end else begin
                    pos_mask = plain_w;
                    neg_mask = '0;
                end
            end
        end else begin : g_plain
            logic unused_mode;
            assign unused_mode = signed_mode;
            assign pos_mask    = plain_w;
            assign neg_mask    = '0;
        end
    endgenerate
endmodule

// File: rtl/low_bit_pick.sv
module low_bit_pick #(
    parameter int unsigned N  = 17,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found,
    output logic          single
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign found  = |vec;
    assign single = found && ((vec & (vec - N'(1))) == '0);
endmodule

// File: rtl/term_serializer.sv
module term_serializer #(
    parameter int unsigned ACT_W     = term_pkg::TP_ACT_W,
    parameter bit          SIGNED_EN = 1'b1,
    localparam int unsigned DW       = ACT_W + 1,
    localparam int unsigned PW       = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ACT_W-1:0] in_act,
    input  logic             in_signed,
    output logic             out_valid,
    output logic [PW-1:0]    out_pos,
    output logic             out_neg,
    output logic             out_zero,
    output logic             out_last
);
    import term_pkg::*;

    typedef struct packed {
        logic          busy;
        enc_mode_e     mode;
        logic          zero;
        logic [DW-1:0] pmask;
        logic [DW-1:0] nmask;
    } ser_state_t;

    ser_state_t st_d, st_q;

    logic [DW-1:0] rec_pos, rec_neg;
    logic [DW-1:0] left_w;
    logic [PW-1:0] pick_idx;
    logic          pick_found, pick_single;
    logic          take;
    logic          run_signed;

    digit_recoder #(
        .ACT_W    (ACT_W),
        .SIGNED_EN(SIGNED_EN)
    ) u_rec (
        .act        (in_act),
        .signed_mode(in_signed),
        .pos_mask   (rec_pos),
        .neg_mask   (rec_neg)
    );

    assign left_w = st_q.pmask | st_q.nmask;

    low_bit_pick #(.N(DW)) u_pick (
        .vec   (left_w),
        .idx   (pick_idx),
        .found (pick_found),
        .single(pick_single)
    );

    assign run_signed = (st_q.mode == ENC_SIGNED);
    assign take       = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.pmask[pick_idx] = 1'b0;
            st_d.nmask[pick_idx] = 1'b0;
            if (st_q.zero || pick_single || !pick_found) begin
                st_d.busy = 1'b0;
                st_d.zero = 1'b0;
            end
        end
        if (take) begin
            st_d.busy  = 1'b1;
            st_d.mode  = in_signed ? ENC_SIGNED : ENC_PLAIN;
            st_d.zero  = (in_act == '0);
            st_d.pmask = rec_pos;
            st_d.nmask = rec_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_zero  = st_q.busy && st_q.zero;
    assign out_pos   = st_q.zero ? '0 : pick_idx;
    assign out_neg   = st_q.busy && run_signed && st_q.nmask[pick_idx];
    assign out_last  = st_q.busy && (st_q.zero || pick_single);
endmodule

// File: rtl/term_serializer_chk.sv
module term_serializer_chk #(
    parameter int unsigned PW = 5,
    parameter int unsigned ACT_W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [PW-1:0] out_pos,
    input logic          out_neg,
    input logic          out_zero,
    input logic          out_last,
    input logic          run_signed
);
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r4_plain_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !run_signed) |-> (!out_neg && out_pos < PW'(ACT_W)));

    a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_pos > $past(out_pos)));

    a_r6_nonadjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && run_signed) |=> (out_pos > ($past(out_pos) + PW'(1))));

    a_r7_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero |-> (out_valid && out_last && out_pos == '0 && !out_neg));

    a_r8_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (!out_valid && in_ready));
endmodule

bind term_serializer term_serializer_chk #(.PW(PW), .ACT_W(ACT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_pos   (out_pos),
    .out_neg   (out_neg),
    .out_zero  (out_zero),
    .out_last  (out_last),
    .run_signed(run_signed)
);

// File: tb/sim_term_serializer.sv
module sim_term_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_act = '0;
    logic        in_signed = 1'b0;
    logic        out_valid;
    logic [4:0]  out_pos;
    logic        out_neg, out_zero, out_last;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    term_serializer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_act(in_act), .in_signed(in_signed), .out_valid(out_valid),
        .out_pos(out_pos), .out_neg(out_neg), .out_zero(out_zero),
        .out_last(out_last)
    );

    // bit 16 = mode (1 signed-digit), bits 15:0 = activation
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 16'h000A}, {1'b0, 16'h002F}, {1'b0, 16'h8001}, {1'b0, 16'hFFFF},
        {1'b0, 16'h1234}, {1'b1, 16'h002F}, {1'b1, 16'h00FF}, {1'b1, 16'hFFFF},
        {1'b1, 16'h5555}, {1'b1, 16'h3B7C}, {1'b1, 16'h000A}, {1'b1, 16'h8000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    // Load one activation and compare every term against a reference digit list.
    task automatic run_one(input logic [15:0] act, input bit sd, input bit noise);
        int ep[17];
        int en[17];
        int n = 0;
        int sum = 0;
        string rq = sd ? "R6" : "R4";
        if (sd) begin
            int x = act;
            int i = 0;
            while (x != 0) begin
                if (x % 2 == 1) begin
                    int d = 2 - (x % 4);
                    ep[n] = i;
                    en[n] = (d < 0) ? 1 : 0;
                    n++;
                    x = x - d;
                end
                x = x / 2;
                i++;
            end
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (act[i]) begin
                    ep[n] = i;
                    en[n] = 0;
                    n++;
                end
            end
        end
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_act    = act;
        in_signed = sd;
        @(negedge clk);
        in_valid = 1'b0;
        if (n == 0) begin
            chk(out_valid && out_zero && out_last && out_pos == 0 && !out_neg,
                "R7", "zero activation term", {out_valid, out_zero, out_last}, 7);
        end else begin
            for (int k = 0; k < n; k++) begin
                chk(out_valid, "R5", "term valid", out_valid, 1);
                chk(!in_ready, "R3", "ready while busy", in_ready, 0);
                chk(out_pos == ep[k], rq, "term position", out_pos, ep[k]);
                chk(out_neg == en[k], rq, "term sign", out_neg, en[k]);
                chk(out_last == (k == n - 1), "R8", "last flag", out_last, k == n - 1);
                chk(!out_zero, "R7", "zero flag on nonzero", out_zero, 0);
                sum += out_neg ? -(1 << out_pos) : (1 << out_pos);
                if (noise) begin
                    in_valid  = !out_last;
                    in_act    = 16'h0001;
                    in_signed = !sd;
                end
                @(negedge clk);
            end
            in_valid = 1'b0;
            chk(sum == int'(act), rq, "rebuilt value", sum, act);
        end
        if (n != 0) begin
            chk(!out_valid && in_ready, "R8", "idle after last", {out_valid, in_ready}, 1);
        end else begin
            @(negedge clk);
            chk(!out_valid && in_ready, "R8", "idle after zero", {out_valid, in_ready}, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid, "R1", "reset state", {in_ready, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1", "after reset", {in_ready, out_valid}, 2);

        for (int v = 0; v < NV; v++) run_one(VEC[v][15:0], VEC[v][16], 1'b0);

        // R2: first term one cycle after capture
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_act = 16'h0010; in_signed = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_pos == 4 && out_last, "R2", "first term timing", out_pos, 4);
        @(negedge clk);

        // R6: 0x002F in signed mode takes exactly three terms
        begin
            int cnt = 0;
            in_valid = 1'b1; in_act = 16'h002F; in_signed = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            while (out_valid) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == 3, "R6", "signed term count 0x2F", cnt, 3);
        end

        // R3: inputs toggling while busy are ignored
        run_one(16'hFFFF, 1'b0, 1'b1);
        run_one(16'hB6DB, 1'b1, 1'b1);

        // R7: zero in both modes
        run_one(16'h0000, 1'b0, 1'b0);
        run_one(16'h0000, 1'b1, 1'b0);

        // R8: idle line stays idle without in_valid
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R8", "quiet idle", out_valid, 0);

        finish_run();
    end
endmodule